// File: doc/BRIEF.md
# Bit-Serial ARX Block Cipher Core

This core encrypts one block of the ARX cipher family built from modular addition, rotation and XOR. It computes one bit per clock. A single full-adder bit and a carry flop do the whole word addition, so an n-bit word takes n clocks for each round. The two state words and the key words sit in shift registers. The round key is produced alongside the data, one bit at a time, by a second copy of the same serial round datapath. That copy adds the round number in place of a key word.

No rotation is ever carried out as a separate step. The left word is read starting at bit α. During the first α clocks of a round, the left register's low part collects the new bits, while its high part takes the old low bits. The right word is read at bit n−β for the first β clocks. After that it is read from a β-bit delay line that holds the bits already shifted out. This delay line stands in for the duplicated high bits of the right word.

To use the core, present plaintext and key and pulse `start` while the core is idle. One clock later the core is busy. When the last bit of the last round has been written, `done` pulses and the ciphertext appears on `ct_x`/`ct_y`. The defaults give the 128-bit block with a 128-bit key. The 32-bit block with a 64-bit key uses WORD=16, KEY_WORDS=4, ROUNDS=22, ALPHA=7, BETA=2.

Top module: `speck_serial_core`

## Requirements
- R1: With the default parameters, key_in=0f0e0d0c0b0a0908_0706050403020100 and plaintext x=6c61766975716520, y=7469206564616d20 give ciphertext x=a65d985179783265, y=7860fedf5c570d18.
- R2: With WORD=16, KEY_WORDS=4, ROUNDS=22, ALPHA=7, BETA=2, key_in=1918_1110_0908_0100 and plaintext x=6574, y=694c give ciphertext x=a868, y=42f2.
- R3: For any plaintext and key, the output equals ROUNDS rounds of x ← (rotr(x,α)+y mod 2^n) ⊕ k, then y ← rotl(y,β) ⊕ x. The round key k comes from the same round applied to (l, k) with the round number 0,1,2,… in place of the key. When KEY_WORDS>2, each new l word joins the back of a queue and the next round takes the oldest.
- R4: If `start` is sampled at clock edge e while idle, `done` is first high after edge e+WORD·ROUNDS, which is one key bit and one data bit per clock.
- R5: `done` is high for exactly one cycle. `busy` is high from the edge after start until the edge that raises `done`, and is low while `done` is high.
- R6: A `start` pulse while `busy` is high is ignored, and the running block finishes with its original result.
- R7: While idle and without `start`, `ct_x` and `ct_y` hold their last value.
- R8: After reset, `busy` and `done` are 0.
- R9: A `start` in the cycle where `done` is high is accepted and begins a new block with the full latency of R4.
- R10: Key layout: key_in[WORD-1:0] is the first round key k0, key_in[2·WORD-1:WORD] is l0, and the next words are l1, l2, … in rising order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load inputs and begin; only acted on when idle |
| key_in | input | KEY_WORDS·WORD | Key words, k0 in the lowest word |
| pt_x | input | WORD | Plaintext left word |
| pt_y | input | WORD | Plaintext right word |
| ct_x | output | WORD | Ciphertext left word |
| ct_y | output | WORD | Ciphertext right word |
| busy | output | 1 | Encryption in progress |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |

## Verification
Two events can fall in the same cycle: a completion (the last bit of the last round, which raises `done`) and the acceptance of a new block through `start`. The bench provokes this by driving `start` in the very cycle it first sees `done` high. It then judges the second ciphertext against the bench model and checks that the second latency is again WORD·ROUNDS. Inside a round, the queue of key words advances on the same clock that writes the last sum bit. The 4-word key variant with random keys exposes any slip there as a wrong ciphertext.

// File: rtl/speck_serial_pkg.sv
package speck_serial_pkg;
  typedef enum logic {
    CORE_IDLE = 1'b0,
    CORE_RUN  = 1'b1
  } core_state_t;
endpackage

// File: rtl/speck_serial_ctrl.sv
module speck_serial_ctrl
  import speck_serial_pkg::*;
#(
  parameter int N = 64,
  parameter int T = 32,
  localparam int IW = $clog2(N),
  localparam int RW = $clog2(T)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ld,
  output logic          en,
  output logic          last_bit,
  output logic [IW-1:0] bit_idx,
  output logic [RW-1:0] rnd,
  output logic          done
);
  core_state_t   st_q, st_n;
  logic [IW-1:0] bit_q, bit_n;
  logic [RW-1:0] rnd_q, rnd_n;
  logic          done_q, done_n;

  always_comb begin
    st_n   = st_q;
    bit_n  = bit_q;
    rnd_n  = rnd_q;
    done_n = 1'b0;
    unique case (st_q)
      CORE_IDLE: begin
        if (start) begin
          st_n  = CORE_RUN;
          bit_n = '0;
          rnd_n = '0;
        end
      end
      CORE_RUN: begin
        if (bit_q == IW'(N-1)) begin
          bit_n = '0;
          if (rnd_q == RW'(T-1)) begin
            st_n   = CORE_IDLE;
            done_n = 1'b1;
          end else begin
            rnd_n = rnd_q + 1'b1;
          end
        end else begin
          bit_n = bit_q + 1'b1;
        end
      end
      default: st_n = CORE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CORE_IDLE;
      bit_q  <= '0;
      rnd_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      bit_q  <= bit_n;
      rnd_q  <= rnd_n;
      done_q <= done_n;
    end
  end

  assign ld       = (st_q == CORE_IDLE) && start;
  assign en       = (st_q == CORE_RUN);
  assign last_bit = en && (bit_q == IW'(N-1));
  assign bit_idx  = bit_q;
  assign rnd      = rnd_q;
  assign done     = done_q;
endmodule

// File: rtl/speck_serial_lane.sv
module speck_serial_lane #(
  parameter int N  = 64,
  parameter int A  = 8,
  parameter int B  = 3,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          en,
  input  logic [N-1:0]  ld_x,
  input  logic [N-1:0]  ld_y,
  input  logic [IW-1:0] bit_idx,
  input  logic          kin,
  input  logic          swap,
  input  logic [N-1:0]  swap_x,
  output logic [N-1:0]  x_q,
  output logic [N-1:0]  y_q,
  output logic          ybit,
  output logic [N-1:0]  x_nxt
);
  logic [N-1:0] xr, xr_n, yr, yr_n, x_step, y_step;
  logic [B-1:0] dl, dl_n, dl_step;
  logic [B:0]   dl_ext;
  logic         cy, cy_n;
  logic         cin, xa, yb, sum_b, cout, xn, yrot, yn;

  always_comb begin
    cin    = (bit_idx == '0) ? 1'b0 : cy;
    xa     = xr[A];
    yb     = yr[0];
    sum_b  = xa ^ yb ^ cin;
    cout   = (xa & yb) | (xa & cin) | (yb & cin);
    xn     = sum_b ^ kin;
    yrot   = (bit_idx < IW'(B)) ? yr[N-B] : dl[B-1];
    yn     = yrot ^ xn;
    x_step = (bit_idx < IW'(A)) ? {xr[0], xr[N-1:A+1], xn, xr[A-1:1]}
                                : {xn, xr[N-1:A+1], xr[A-1:0]};
    y_step = {yn, yr[N-1:1]};
    dl_ext = {dl, yr[0]};
    dl_step = dl_ext[B-1:0];

    xr_n = xr;
    yr_n = yr;
    dl_n = dl;
    cy_n = cy;
    if (ld) begin
      xr_n = ld_x;
      yr_n = ld_y;
      cy_n = 1'b0;
    end else if (en) begin
      xr_n = swap ? swap_x : x_step;
      yr_n = y_step;
      dl_n = dl_step;
      cy_n = cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr <= '0;
      yr <= '0;
      dl <= '0;
      cy <= 1'b0;
    end else begin
      xr <= xr_n;
      yr <= yr_n;
      dl <= dl_n;
      cy <= cy_n;
    end
  end

  assign x_q   = xr;
  assign y_q   = yr;
  assign ybit  = yr[0];
  assign x_nxt = x_step;
endmodule

// File: rtl/speck_key_queue.sv
module speck_key_queue #(
  parameter int N     = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [DEPTH*N-1:0] ld_words,
  input  logic             adv,
  input  logic [N-1:0]     push,
  output logic [N-1:0]     front
);
  logic [N-1:0] q   [DEPTH];
  logic [N-1:0] q_n [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    always_comb begin
      q_n[j] = q[j];
      if (ld) begin
        q_n[j] = ld_words[j*N +: N];
      end else if (adv) begin
        if (j == DEPTH-1) q_n[j] = push;
        else              q_n[j] = q[(j+1) % DEPTH];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[j] <= '0;
      else        q[j] <= q_n[j];
    end
  end

  assign front = q[0];
endmodule

// File: rtl/speck_serial_core.sv
module speck_serial_core #(
  parameter int WORD      = 64,
  parameter int KEY_WORDS = 2,
  parameter int ROUNDS    = 32,
  parameter int ALPHA     = 8,
  parameter int BETA      = 3,
  localparam int IW = $clog2(WORD),
  localparam int RW = $clog2(ROUNDS),
  localparam int KW = KEY_WORDS * WORD
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [KW-1:0]   key_in,
  input  logic [WORD-1:0] pt_x,
  input  logic [WORD-1:0] pt_y,
  output logic [WORD-1:0] ct_x,
  output logic [WORD-1:0] ct_y,
  output logic            busy,
  output logic            done
);
  logic            ld, en, last_bit;
  logic [IW-1:0]   bit_idx;
  logic [RW-1:0]   rnd;
  logic [WORD-1:0] rnd_ext;
  logic            rkey_bit, sched_kin, key_swap;
  logic [WORD-1:0] key_front, key_push;
  logic [WORD-1:0] dat_x, dat_y, dat_nxt, sch_x, sch_y;
  logic            dat_ybit;

  speck_serial_ctrl #(.N(WORD), .T(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ld(ld), .en(en),
    .last_bit(last_bit), .bit_idx(bit_idx), .rnd(rnd), .done(done)
  );

  assign rnd_ext   = WORD'(rnd);
  assign sched_kin = rnd_ext[bit_idx];

  speck_serial_lane #(.N(WORD), .A(ALPHA), .B(BETA)) u_sched (
    .clk(clk), .rst_n(rst_n), .ld(ld), .en(en),
    .ld_x(key_in[2*WORD-1:WORD]), .ld_y(key_in[WORD-1:0]),
    .bit_idx(bit_idx), .kin(sched_kin),
    .swap(key_swap), .swap_x(key_front),
    .x_q(sch_x), .y_q(sch_y), .ybit(rkey_bit), .x_nxt(key_push)
  );

  if (KEY_WORDS > 2) begin : g_queue
    speck_key_queue #(.N(WORD), .DEPTH(KEY_WORDS-2)) u_queue (
      .clk(clk), .rst_n(rst_n), .ld(ld),
      .ld_words(key_in[KW-1:2*WORD]),
      .adv(last_bit), .push(key_push), .front(key_front)
    );
    assign key_swap = last_bit;
  end else begin : g_noqueue
    assign key_front = '0;
    assign key_swap  = 1'b0;
  end

  speck_serial_lane #(.N(WORD), .A(ALPHA), .B(BETA)) u_data (
    .clk(clk), .rst_n(rst_n), .ld(ld), .en(en),
    .ld_x(pt_x), .ld_y(pt_y),
    .bit_idx(bit_idx), .kin(rkey_bit),
    .swap(1'b0), .swap_x({WORD{1'b0}}),
    .x_q(dat_x), .y_q(dat_y), .ybit(dat_ybit), .x_nxt(dat_nxt)
  );

  assign ct_x = dat_x;
  assign ct_y = dat_y;
  assign busy = en;
endmodule

// File: rtl/speck_serial_chk.sv
module speck_serial_chk #(
  parameter int N = 64,
  parameter int T = 32,
  localparam int CW = $clog2(N*T+2)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] ct_x,
  input logic [N-1:0] ct_y
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (run_cnt == CW'(N*T)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_busy_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(ct_x) && $stable(ct_y)));
endmodule

bind speck_serial_core speck_serial_chk #(.N(WORD), .T(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ct_x(ct_x), .ct_y(ct_y)
);

// File: tb/sim_speck_serial_core.sv
`timescale 1ns/1ps
module sim_speck_serial_core;
  logic clk, rst_n;
  logic start_a, start_b;
  logic [127:0] key_a;
  logic [63:0]  pxa, pya, cxa, cya;
  logic [63:0]  key_b;
  logic [15:0]  pxb, pyb, cxb, cyb;
  logic busy_a, done_a, busy_b, done_b;
  int n_chk, n_fail;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  speck_serial_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start_a), .key_in(key_a),
    .pt_x(pxa), .pt_y(pya), .ct_x(cxa), .ct_y(cya), .busy(busy_a), .done(done_a)
  );

  speck_serial_core #(.WORD(16), .KEY_WORDS(4), .ROUNDS(22), .ALPHA(7), .BETA(2)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start_b), .key_in(key_b),
    .pt_x(pxb), .pt_y(pyb), .ct_x(cxb), .ct_y(cyb), .busy(busy_b), .done(done_b)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rot_r(input logic [63:0] v, input int r, input int n);
    logic [63:0] m;
    m = (n == 64) ? '1 : ((64'd1 << n) - 1);
    return ((v >> r) | (v << (n - r))) & m;
  endfunction

  function automatic logic [63:0] rot_l(input logic [63:0] v, input int r, input int n);
    return rot_r(v, n - r, n);
  endfunction

  function automatic logic [127:0] model(input int n, input int m, input int t,
      input int a, input int b, input logic [127:0] key,
      input logic [63:0] px, input logic [63:0] py);
    logic [63:0] msk, x, y, k;
    logic [63:0] l [64];
    msk = (n == 64) ? '1 : ((64'd1 << n) - 1);
    k = key[63:0] & msk;
    for (int j = 0; j < m - 1; j++) l[j] = (key >> ((j + 1) * n)) & msk;
    x = px; y = py;
    for (int i = 0; i < t; i++) begin
      x = ((rot_r(x, a, n) + y) & msk) ^ k;
      y = rot_l(y, b, n) ^ x;
      l[i + m - 1] = ((k + rot_r(l[i], a, n)) & msk) ^ 64'(i);
      k = rot_l(k, b, n) ^ l[i + m - 1];
    end
    return {x, y};
  endfunction

  task automatic kick(input int sel, input logic [127:0] k, input logic [63:0] px,
                      input logic [63:0] py);
    if (sel == 0) begin
      key_a = k; pxa = px; pya = py; start_a = 1'b1;
    end else begin
      key_b = k[63:0]; pxb = px[15:0]; pyb = py[15:0]; start_b = 1'b1;
    end
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
  endtask

  task automatic wait_done(input int sel, output logic [63:0] cx, output logic [63:0] cy,
                           output int lat);
    lat = 0;
    while (!((sel == 0) ? done_a : done_b) && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    cx = (sel == 0) ? cxa : {48'b0, cxb};
    cy = (sel == 0) ? cya : {48'b0, cyb};
  endtask

  task automatic run_cmp(input int sel, input logic [127:0] k, input logic [63:0] px,
                         input logic [63:0] py, input string req);
    logic [63:0] cx, cy;
    logic [127:0] e;
    int lat;
    if (sel == 0) e = model(64, 2, 32, 8, 3, k, px, py);
    else          e = model(16, 4, 22, 7, 2, {64'b0, k[63:0]}, px & 64'hffff, py & 64'hffff);
    kick(sel, k, px, py);
    wait_done(sel, cx, cy, lat);
    chk(req, cx, e[127:64]);
    chk(req, cy, e[63:0]);
    chk("R4 latency", 64'(lat), (sel == 0) ? 64'd2048 : 64'd352);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] cx, cy, hx, hy;
    logic [127:0] e;
    int lat;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    start_a = 0; start_b = 0; key_a = '0; key_b = '0;
    pxa = '0; pya = '0; pxb = '0; pyb = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy", {62'b0, busy_a, busy_b}, 64'd0);
    chk("R8 done", {62'b0, done_a, done_b}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after release", {62'b0, busy_a, done_a}, 64'd0);

    // R1 published vector, wide variant
    kick(0, 128'h0f0e0d0c0b0a0908_0706050403020100, 64'h6c61766975716520, 64'h7469206564616d20);
    wait_done(0, cx, cy, lat);
    chk("R1 ct_x", cx, 64'ha65d985179783265);
    chk("R1 ct_y", cy, 64'h7860fedf5c570d18);
    chk("R4 latency wide", 64'(lat), 64'd2048);
    @(negedge clk);
    chk("R5 done one cycle", {62'b0, done_a, busy_a}, 64'd0);
    hx = cxa; hy = cya;
    repeat (20) @(negedge clk);
    chk("R7 hold x", cxa, hx);
    chk("R7 hold y", cya, hy);

    // R2 published vector, narrow variant
    kick(1, {64'b0, 64'h1918_1110_0908_0100}, 64'h6574, 64'h694c);
    wait_done(1, cx, cy, lat);
    chk("R2 ct_x", cx, 64'ha868);
    chk("R2 ct_y", cy, 64'h42f2);
    chk("R4 latency narrow", 64'(lat), 64'd352);

    // R3 random blocks in both variants
    for (int i = 0; i < 3; i++) begin
      run_cmp(0, {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, "R3 random wide");
      run_cmp(1, {64'b0, $urandom, $urandom}, 64'($urandom), 64'($urandom), "R3 random narrow");
    end

    // R10 key word placement: only one word nonzero at a time
    run_cmp(1, {64'b0, 16'h00a5, 48'h0}, 64'h1234, 64'h5678, "R10 top l word");
    run_cmp(1, {64'b0, 48'h0, 16'h5a00}, 64'h1234, 64'h5678, "R10 k0 word");
    run_cmp(0, {64'h0123456789abcdef, 64'h0}, 64'h0, 64'h0, "R10 l0 word");

    // R6 start while busy is ignored
    e = model(16, 4, 22, 7, 2, {64'b0, 64'h0f1e2d3c4b5a6978}, 64'h3344, 64'hcafe);
    kick(1, {64'b0, 64'h0f1e2d3c4b5a6978}, 64'h3344, 64'hcafe);
    repeat (100) @(negedge clk);
    kick(1, {64'b0, 64'hffffffffffffffff}, 64'h0000, 64'h1111);
    wait_done(1, cx, cy, lat);
    chk("R6 ignored start x", cx, e[127:64]);
    chk("R6 ignored start y", cy, e[63:0]);

    // R9 start in the done cycle is accepted (done_b is high now)
    e = model(16, 4, 22, 7, 2, {64'b0, 64'h0102030405060708}, 64'hbeef, 64'h0bad);
    kick(1, {64'b0, 64'h0102030405060708}, 64'hbeef, 64'h0bad);
    wait_done(1, cx, cy, lat);
    chk("R9 back-to-back x", cx, e[127:64]);
    chk("R9 back-to-back y", cy, e[63:0]);
    chk("R9 back-to-back latency", 64'(lat), 64'd352);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule